// File: doc/BRIEF.md
# Orthogonal Latin Square Single-Error Corrector

This block repairs a 16-bit data word read from a memory protected by an orthogonal Latin square code with m = 4 and single-error correction. It receives the eight syndrome bits, which an upstream circuit has already computed, together with the received data. Each data bit is checked by exactly two syndrome bits, one from the row group and one from the column group. Two data bits never share more than one check. Each data bit therefore gets its own one-step majority vote: the bit is inverted only when both of its checks fail. No table lookup from syndrome to bit position is needed.

A classifier looks at the weight and the shape of the syndrome. It raises exactly one of three flags: clean (no error), fixed (one data bit inverted, or one check bit in error), or bad (a pattern no single error can produce). On a bad pattern the data passes through unchanged. The result is registered, so it appears one clock after the input is presented.

Top module: `ols_corrector`

## Requirements
- R1: Data bit index a*M+b (0-based, row a, column b) is checked by syndrome bits a and M+b, where syndrome bit k is check k+1. When exactly those two syndrome bits are set, that data bit alone is inverted and the fixed flag is raised.
- R2: An all-zero syndrome passes the data through unchanged and raises the clean flag.
- R3: A syndrome with exactly one bit set is treated as a check-bit error: the data is unchanged and the fixed flag is raised.
- R4: A weight-2 syndrome whose two bits both lie in the row group (bits 0..M-1) or both in the column group (bits M..2M-1) matches no data bit. It raises the bad flag and leaves the data unchanged.
- R5: A syndrome of weight 3 or more raises the bad flag and leaves the data unchanged.
- R6: Every valid output carries exactly one of the flags clean, fixed and bad. At most one data bit differs from the input.
- R7: out_valid is high exactly one cycle after in_valid. In a cycle without in_valid, out_valid is low and data_out and the flags hold their values.
- R8: While rst_n is low, out_valid, data_out and all flags are zero.
- R9: For any codeword with any single data bit flipped, data_out equals the original data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Syndrome and data are present |
| syn_in | input | 8 | Syndrome, bit k is check k+1 |
| data_in | input | 16 | Received data word |
| out_valid | output | 1 | Registered result is new this cycle |
| data_out | output | 16 | Corrected data |
| flag_clean | output | 1 | Syndrome was zero |
| flag_fixed | output | 1 | One data or check bit was in error |
| flag_bad | output | 1 | Pattern beyond single-error correction |

## Verification
A vector table covers the zero syndrome, which tells pass-through apart from any flip. It also places corner-of-grid pairs such as rows 0 and 3 against columns 0 and 3, which catch a swapped row/column index. Random codewords are then encoded by the bench's own parity function, and each of the 16 data bits is flipped in turn, so a wrong vote for any single bit shows up. Flips of each stored check bit give weight-1 syndromes, which separate a check error from a data error. Double data errors in one row give same-group pairs, and double errors in different rows and columns give weight 4; together these separate the two paths to the bad flag.

// File: rtl/ols_pkg.sv
package ols_pkg;

  typedef enum logic [1:0] {
    VERDICT_CLEAN = 2'd0,
    VERDICT_FIXED = 2'd1,
    VERDICT_BAD   = 2'd2
  } verdict_e;

endpackage

// File: rtl/ols_vote.sv
// One-step majority vote: each data bit sees its row check and its column check.
module ols_vote #(
  parameter int M = 4
) (
  input  logic [2*M-1:0] syn,
  output logic [M*M-1:0] flip_req
);

  // Both of the bit's two checks must fail.
  function automatic logic majority2(input logic row_chk, input logic col_chk);
    return row_chk & col_chk;
  endfunction

  for (genvar a = 0; a < M; a++) begin : g_row
    for (genvar b = 0; b < M; b++) begin : g_col
      assign flip_req[a*M+b] = majority2(syn[a], syn[M+b]);
    end
  end

endmodule

// File: rtl/ols_classify.sv
// Sorts the syndrome by weight and shape into clean / fixed / bad.
module ols_classify
  import ols_pkg::*;
#(
  parameter int M = 4
) (
  input  logic [2*M-1:0] syn,
  output verdict_e       verdict,
  output logic           apply_flip
);

  localparam int SW = 2 * M;

  function automatic int unsigned weight_of(input logic [SW-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < SW; i++) n += int'(v[i]);
    return n;
  endfunction

  logic        row_hit;
  logic        col_hit;
  int unsigned wt;

  assign row_hit = |syn[M-1:0];
  assign col_hit = |syn[SW-1:M];
  assign wt      = weight_of(syn);

  always_comb begin
    verdict    = VERDICT_BAD;
    apply_flip = 1'b0;
    if (wt == 0) begin
      verdict = VERDICT_CLEAN;
    end else if (wt == 1) begin
      verdict = VERDICT_FIXED;
    end else if (wt == 2 && row_hit && col_hit) begin
      verdict    = VERDICT_FIXED;
      apply_flip = 1'b1;
    end
  end

endmodule

// File: rtl/ols_corrector.sv
module ols_corrector
  import ols_pkg::*;
#(
  parameter int M = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [2*M-1:0]       syn_in,
  input  logic [M*M-1:0]       data_in,
  output logic                 out_valid,
  output logic [M*M-1:0]       data_out,
  output logic                 flag_clean,
  output logic                 flag_fixed,
  output logic                 flag_bad
);

  localparam int DW = M * M;

  logic [DW-1:0] flip_req;
  logic [DW-1:0] flip_mask;
  logic [DW-1:0] repaired;
  verdict_e      verdict;
  logic          apply_flip;

  ols_vote #(.M(M)) u_vote (
    .syn      (syn_in),
    .flip_req (flip_req)
  );

  ols_classify #(.M(M)) u_class (
    .syn        (syn_in),
    .verdict    (verdict),
    .apply_flip (apply_flip)
  );

  assign flip_mask = apply_flip ? flip_req : '0;
  assign repaired  = data_in ^ flip_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      data_out   <= '0;
      flag_clean <= 1'b0;
      flag_fixed <= 1'b0;
      flag_bad   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        data_out   <= repaired;
        flag_clean <= (verdict == VERDICT_CLEAN);
        flag_fixed <= (verdict == VERDICT_FIXED);
        flag_bad   <= (verdict == VERDICT_BAD);
      end
    end
  end

endmodule

// File: rtl/ols_corrector_chk.sv
module ols_corrector_chk #(
  parameter int M = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [2*M-1:0] syn_in,
  input logic [M*M-1:0] data_in,
  input logic [M*M-1:0] flip_mask,
  input logic           out_valid,
  input logic [M*M-1:0] data_out,
  input logic           flag_clean,
  input logic           flag_fixed,
  input logic           flag_bad
);

  // R1: the combined vote never selects more than one data bit.
  a_r1_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(flip_mask) <= 1);

  a_r2_clean_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && syn_in == '0) |=> (flag_clean && data_out == $past(data_in)));

  a_r3_check_error: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && $countones(syn_in) == 1) |=> (flag_fixed && data_out == $past(data_in)));

  a_r4_same_group: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && $countones(syn_in) == 2 &&
     (syn_in[2*M-1:M] == '0 || syn_in[M-1:0] == '0))
    |=> (flag_bad && data_out == $past(data_in)));

  a_r5_heavy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && $countones(syn_in) > 2) |=> (flag_bad && data_out == $past(data_in)));

  a_r6_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({flag_bad, flag_fixed, flag_clean}) == 1);

  a_r6_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> $countones(data_out ^ $past(data_in)) <= 1);

  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid) |=> (!out_valid && $stable(data_out) && $stable(flag_bad)));

endmodule

bind ols_corrector ols_corrector_chk #(.M(M)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .syn_in     (syn_in),
  .data_in    (data_in),
  .flip_mask  (flip_mask),
  .out_valid  (out_valid),
  .data_out   (data_out),
  .flag_clean (flag_clean),
  .flag_fixed (flag_fixed),
  .flag_bad   (flag_bad)
);

// File: tb/ols_corrector_bench.sv
`timescale 1ns/1ps
module ols_corrector_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  syn_in = '0;
  logic [15:0] data_in = '0;
  logic        out_valid;
  logic [15:0] data_out;
  logic        flag_clean, flag_fixed, flag_bad;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ols_corrector u_ols_corrector (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .syn_in(syn_in),
    .data_in(data_in), .out_valid(out_valid), .data_out(data_out),
    .flag_clean(flag_clean), .flag_fixed(flag_fixed), .flag_bad(flag_bad)
  );

  // {syndrome, data in, expected data, expected {bad,fixed,clean}}
  localparam logic [42:0] VEC [0:10] = '{
    {8'h00, 16'hA5A5, 16'hA5A5, 3'b001},  // R2 zero syndrome
    {8'h11, 16'h0000, 16'h0001, 3'b010},  // R1 checks 0,4 -> bit 0
    {8'h22, 16'h0000, 16'h0020, 3'b010},  // R1 checks 1,5 -> bit 5
    {8'h88, 16'hFFFF, 16'h7FFF, 3'b010},  // R1 checks 3,7 -> bit 15
    {8'h41, 16'h1234, 16'h1230, 3'b010},  // R1 checks 0,6 -> bit 2
    {8'h14, 16'h0100, 16'h0000, 3'b010},  // R1 checks 2,4 -> bit 8
    {8'h10, 16'hBEEF, 16'hBEEF, 3'b010},  // R3 single check bit
    {8'h03, 16'hBEEF, 16'hBEEF, 3'b100},  // R4 two row checks
    {8'h30, 16'hBEEF, 16'hBEEF, 3'b100},  // R4 two column checks
    {8'h07, 16'h5555, 16'h5555, 3'b100},  // R5 weight 3
    {8'hFF, 16'h5555, 16'h5555, 3'b100}   // R5 all set
  };

  function automatic logic [7:0] encode(input logic [15:0] w);
    logic [7:0] c;
    for (int a = 0; a < 4; a++) c[a] = ^w[a*4 +: 4];
    for (int b = 0; b < 4; b++) c[4+b] = w[b] ^ w[4+b] ^ w[8+b] ^ w[12+b];
    return c;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [7:0] s, input logic [15:0] d);
    @(negedge clk);
    syn_in = s; data_in = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_out(input string tag, input logic [15:0] d, input logic [2:0] f);
    check({tag, " data"}, {16'h0, data_out}, {16'h0, d});
    check({tag, " flags"}, {28'h0, out_valid, flag_bad, flag_fixed, flag_clean}, {28'h0, 1'b1, f});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 reset", {28'h0, out_valid, flag_bad, flag_fixed, flag_clean}, 32'h0);
    check("R8 reset data", {16'h0, data_out}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < 11; i++) begin
      apply(VEC[i][42:35], VEC[i][34:19]);
      expect_out($sformatf("table %0d (R1-table)", i), VEC[i][18:3], VEC[i][2:0]);
    end

    // R7: idle cycle drops out_valid, holds data
    @(negedge clk);
    check("R7 idle valid", {31'h0, out_valid}, 32'h0);
    check("R7 idle hold", {16'h0, data_out}, {16'h0, VEC[10][18:3]});

    for (int n = 0; n < 4; n++) begin
      logic [15:0] orig;
      logic [7:0]  chk;
      orig = 16'($urandom);
      chk  = encode(orig);
      // R9 every single data-bit flip
      for (int i = 0; i < 16; i++) begin
        logic [15:0] rx;
        rx = orig ^ (16'h1 << i);
        apply(encode(rx) ^ chk, rx);
        expect_out($sformatf("R9 cw%0d bit%0d", n, i), orig, 3'b010);
      end
      // R3 stored check-bit flips
      for (int k = 0; k < 8; k++) begin
        apply(encode(orig) ^ (chk ^ (8'h1 << k)), orig);
        expect_out($sformatf("R3 cw%0d chk%0d", n, k), orig, 3'b010);
      end
      // R4 two flips in one row
      begin
        logic [15:0] rx;
        rx = orig ^ 16'h0003;
        apply(encode(rx) ^ chk, rx);
        expect_out($sformatf("R4 cw%0d same row", n), rx, 3'b100);
        // R5 two flips in different rows and columns
        rx = orig ^ 16'h0021;
        apply(encode(rx) ^ chk, rx);
        expect_out($sformatf("R5 cw%0d diagonal pair", n), rx, 3'b100);
        // R2 clean codeword
        apply(encode(orig) ^ chk, orig);
        expect_out($sformatf("R2 cw%0d clean", n), orig, 3'b001);
      end
    end

    // R8 reset mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 rerun reset", {15'h0, out_valid, data_out}, 32'h0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule